// File: doc/BRIEF.md
# External Data Access Router and Address Latch Strobe Generator

This block sits beside the CPU of a small 8-bit microcontroller core. For every external-data move it decides whether the access is served by the on-chip expanded data RAM or sent out to the external bus. The decision depends on one mode bit in a control register and on where the effective address falls relative to 100H. An access that uses an 8-bit pointer register has its address zero-extended. Such an access therefore always falls below the boundary.

The block also drives the address latch enable (ALE) strobe. In free-running mode, ALE pulses for one oscillator clock once per machine phase group. The pulse comes every 3 clocks in 6-clock mode and every 6 clocks in 12-clock mode. When the strobe-suppress bit is set, the pulse train reaches the pin only while the CPU flags an external-data or code-table move. The control register sits at SFR address 8EH and is written through a simple register port. The unused bits read back as ones.

Top module: `xmem_ale_ctrl`

## Requirements
- R1: After reset the register reads 8'hFE: bit 1 (external-only routing) is 1, bit 0 (strobe suppress) is 0, and bits 7..2 are 1.
- R2: A write with reg_addr_i equal to 8EH loads bits 1..0 from reg_wdata_i at the next clock edge. A write to any other address leaves the register unchanged.
- R3: Bits 7..2 always read as 1, and writing them has no effect.
- R4: With bit 1 = 0 and acc_valid_i = 1, an effective address of FFH or below asserts int_ram_sel_o and deasserts ext_bus_sel_o.
- R5: With bit 1 = 0, an effective address of 100H or above asserts ext_bus_sel_o only.
- R6: With bit 1 = 1, every valid access asserts ext_bus_sel_o only, whatever the address.
- R7: When acc_ri_i = 1, only acc_addr_i[7:0] is used, zero-extended, so the access is internal when bit 1 = 0.
- R8: With acc_valid_i = 0, both selects are 0, and the two selects are never both 1.
- R9: With bit 0 = 0 and clk_mode6_i = 1, ALE is high for one clock in every 3 clocks.
- R10: With bit 0 = 0 and clk_mode6_i = 0, ALE is high for one clock in every 6 clocks.
- R11: With bit 0 = 1, ALE stays low unless instr_movx_i or instr_movc_i is 1. While either flag is 1, ALE keeps the free-running rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | SFR address of the write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Current register value |
| acc_valid_i | input | 1 | External-data move in progress |
| acc_ri_i | input | 1 | Access uses an 8-bit pointer register |
| acc_addr_i | input | ADDR_W | Access address |
| instr_movx_i | input | 1 | External-data move instruction executing |
| instr_movc_i | input | 1 | Code-table move instruction executing |
| clk_mode6_i | input | 1 | 1 = 6-clock mode, 0 = 12-clock mode |
| int_ram_sel_o | output | 1 | Route access to expanded RAM |
| ext_bus_sel_o | output | 1 | Route access to external bus |
| ale_o | output | 1 | Address latch enable |

## Verification
The hardest case to reach is a strobe-suppressed ALE that must still pulse at the correct rate while an instruction flag is held. Reaching it needs a register write first, then the flag held across a whole counting window after the divider has settled. The bench writes bit 0 and counts pulses with the flags low. It then holds instr_movx_i for the same window and finally switches clock modes, leaving settling cycles before each count. The routing boundary is covered by testing FFH and 100H under both routing settings, and by an 8-bit-pointer access whose upper address bits are set.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam logic [7:0] CFG_SFR_ADDR = 8'h8E;
  localparam int unsigned BIT_EXT  = 1;
  localparam int unsigned BIT_AOFF = 0;

  typedef struct packed {
    logic ext_only;
    logic ale_off;
  } xmem_cfg_t;

  localparam xmem_cfg_t CFG_RESET = '{ext_only: 1'b1, ale_off: 1'b0};
endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg
  import xmem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output xmem_cfg_t  cfg_o,
  output logic [7:0] rdata_o
);
  xmem_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
    end else if (wr_i && addr_i == CFG_SFR_ADDR) begin
      cfg_q.ext_only <= wdata_i[BIT_EXT];
      cfg_q.ale_off  <= wdata_i[BIT_AOFF];
    end
  end

  always_comb begin
    rdata_o           = 8'hFF;
    rdata_o[BIT_EXT]  = cfg_q.ext_only;
    rdata_o[BIT_AOFF] = cfg_q.ale_off;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/xmem_route.sv
module xmem_route #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned IRAM_DEPTH = 256
) (
  input  logic              ext_only_i,
  input  logic              valid_i,
  input  logic              ri_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              int_sel_o,
  output logic              ext_sel_o
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(IRAM_DEPTH);

  logic [ADDR_W-1:0] eff_addr;
  logic              in_iram;

  // 8-bit pointer form: zero-extend low byte
  assign eff_addr  = ri_i ? {{(ADDR_W-8){1'b0}}, addr_i[7:0]} : addr_i;
  assign in_iram   = eff_addr < LIMIT;
  assign int_sel_o = valid_i & ~ext_only_i & in_iram;
  assign ext_sel_o = valid_i & ~(~ext_only_i & in_iram);
endmodule

// File: rtl/xmem_ale_gen.sv
module xmem_ale_gen #(
  parameter int unsigned DIV6  = 3,
  parameter int unsigned DIV12 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode6_i,
  input  logic ale_off_i,
  input  logic movx_i,
  input  logic movc_i,
  output logic ale_o
);
  localparam int unsigned CNT_W = $clog2(DIV12 > DIV6 ? DIV12 : DIV6);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;
  logic             pulse_q;

  assign last = mode6_i ? CNT_W'(DIV6 - 1) : CNT_W'(DIV12 - 1);
  assign wrap = cnt_q >= last;  // also catches a mode change mid-period

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= wrap ? '0 : cnt_q + 1'b1;
      pulse_q <= wrap;
    end
  end

  assign ale_o = pulse_q & (~ale_off_i | movx_i | movc_i);
endmodule

// File: rtl/xmem_ale_ctrl.sv
module xmem_ale_ctrl
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned IRAM_DEPTH = 256,
  parameter int unsigned DIV6       = 3,
  parameter int unsigned DIV12      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic              acc_ri_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              instr_movx_i,
  input  logic              instr_movc_i,
  input  logic              clk_mode6_i,
  output logic              int_ram_sel_o,
  output logic              ext_bus_sel_o,
  output logic              ale_o
);
  xmem_cfg_t cfg;

  xmem_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (reg_rdata_o)
  );

  xmem_route #(.ADDR_W(ADDR_W), .IRAM_DEPTH(IRAM_DEPTH)) u_route (
    .ext_only_i (cfg.ext_only),
    .valid_i    (acc_valid_i),
    .ri_i       (acc_ri_i),
    .addr_i     (acc_addr_i),
    .int_sel_o  (int_ram_sel_o),
    .ext_sel_o  (ext_bus_sel_o)
  );

  xmem_ale_gen #(.DIV6(DIV6), .DIV12(DIV12)) u_ale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode6_i   (clk_mode6_i),
    .ale_off_i (cfg.ale_off),
    .movx_i    (instr_movx_i),
    .movc_i    (instr_movc_i),
    .ale_o     (ale_o)
  );
endmodule

// File: rtl/xmem_ale_ctrl_chk.sv
module xmem_ale_ctrl_chk
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [7:0]        reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic              acc_valid_i,
  input logic              acc_ri_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              instr_movx_i,
  input logic              instr_movc_i,
  input logic              clk_mode6_i,
  input logic              int_ram_sel_o,
  input logic              ext_bus_sel_o,
  input logic              ale_o
);
  assert_sel_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_ram_sel_o, ext_bus_sel_o}));

  assert_idle_no_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !int_ram_sel_o && !ext_bus_sel_o);

  assert_ext_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1] && acc_valid_i |-> ext_bus_sel_o);

  assert_unused_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:2] == 6'h3F);

  assert_other_addr_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i != CFG_SFR_ADDR |=> $stable(reg_rdata_o));

  assert_ale_suppressed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[0] && !instr_movx_i && !instr_movc_i |-> !ale_o);

  assert_ale_one_clock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
endmodule

bind xmem_ale_ctrl xmem_ale_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_xmem_ale_ctrl.sv
`timescale 1ns/1ps
module tb_xmem_ale_ctrl;
  localparam int unsigned ADDR_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_wr_i = 1'b0;
  logic [7:0]        reg_addr_i = '0;
  logic [7:0]        reg_wdata_i = '0;
  logic [7:0]        reg_rdata_o;
  logic              acc_valid_i = 1'b0;
  logic              acc_ri_i = 1'b0;
  logic [ADDR_W-1:0] acc_addr_i = '0;
  logic              instr_movx_i = 1'b0;
  logic              instr_movc_i = 1'b0;
  logic              clk_mode6_i = 1'b1;
  logic              int_ram_sel_o;
  logic              ext_bus_sel_o;
  logic              ale_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp_int;
    logic  exp_ext;
    string tag;
  } route_item_t;

  route_item_t sb_q[$];

  always #10 clk_i = ~clk_i;

  xmem_ale_ctrl #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected routing items at the falling edge
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      route_item_t it;
      it = sb_q.pop_front();
      check(int_ram_sel_o == it.exp_int && ext_bus_sel_o == it.exp_ext, it.tag,
            {int_ram_sel_o, ext_bus_sel_o}, {it.exp_int, it.exp_ext});
    end
  end

  task automatic drive_acc(input logic v, input logic ri, input logic [ADDR_W-1:0] a,
                           input logic ext_only, input string tag);
    route_item_t it;
    logic in_ram;
    @(posedge clk_i); #2;
    acc_valid_i = v; acc_ri_i = ri; acc_addr_i = a;
    in_ram = (ri ? {8'h0, a[7:0]} : a) < 16'h100;
    it.exp_int = v & ~ext_only & in_ram;
    it.exp_ext = v & ~(~ext_only & in_ram);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk_i); #2;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #2;
    reg_wr_i = 1'b0;
  endtask

  task automatic count_ale(input int settle, input int win, output int n);
    n = 0;
    repeat (settle) @(posedge clk_i);
    for (int i = 0; i < win; i++) begin
      @(negedge clk_i);
      if (ale_o) n++;
    end
  endtask

  initial begin
    int n;
    #55 rst_ni = 1'b1;
    @(negedge clk_i);
    check(reg_rdata_o == 8'hFE, "R1 reset value", reg_rdata_o, 8'hFE);
    check(ale_o == 1'b0, "R1 ale low after reset", ale_o, 0);

    // ext-only routing (reset state)
    drive_acc(1'b1, 1'b0, 16'h00FF, 1'b1, "R6 FFH ext-only");
    drive_acc(1'b1, 1'b0, 16'h0100, 1'b1, "R6 100H ext-only");
    drive_acc(1'b0, 1'b0, 16'h0010, 1'b1, "R8 idle");
    @(negedge clk_i); @(negedge clk_i);

    // other-address write ignored
    write_reg(8'h8F, 8'h00);
    @(negedge clk_i);
    check(reg_rdata_o == 8'hFE, "R2 other address ignored", reg_rdata_o, 8'hFE);

    // select internal, unused bits written 0
    write_reg(8'h8E, 8'h00);
    @(negedge clk_i);
    check(reg_rdata_o == 8'hFC, "R3 unused bits read 1", reg_rdata_o, 8'hFC);
    check(reg_rdata_o[1:0] == 2'b00, "R2 write loads bits", reg_rdata_o[1:0], 0);

    drive_acc(1'b1, 1'b0, 16'h00FF, 1'b0, "R4 FFH internal");
    drive_acc(1'b1, 1'b0, 16'h0000, 1'b0, "R4 00H internal");
    drive_acc(1'b1, 1'b0, 16'h0100, 1'b0, "R5 100H external");
    drive_acc(1'b1, 1'b0, 16'hFFFF, 1'b0, "R5 FFFFH external");
    drive_acc(1'b1, 1'b1, 16'hAB80, 1'b0, "R7 pointer zero-extend");
    drive_acc(1'b0, 1'b0, 16'h0005, 1'b0, "R8 idle internal mode");
    @(negedge clk_i); @(negedge clk_i);
    acc_valid_i = 1'b0;

    // free-running ALE
    clk_mode6_i = 1'b1;
    count_ale(8, 60, n);
    check(n == 20, "R9 6-clock ALE rate", n, 20);
    clk_mode6_i = 1'b0;
    count_ale(8, 60, n);
    check(n == 10, "R10 12-clock ALE rate", n, 10);

    // suppressed ALE
    write_reg(8'h8E, 8'h01);
    @(negedge clk_i);
    check(reg_rdata_o == 8'hFD, "R2 ale_off set", reg_rdata_o, 8'hFD);
    count_ale(2, 60, n);
    check(n == 0, "R11 suppressed without instr", n, 0);
    instr_movx_i = 1'b1;
    count_ale(0, 60, n);
    check(n == 10, "R11 movx 12-clock", n, 10);
    instr_movx_i = 1'b0; instr_movc_i = 1'b1; clk_mode6_i = 1'b1;
    count_ale(8, 30, n);
    check(n == 10, "R11 movc 6-clock", n, 10);
    instr_movc_i = 1'b0;
    count_ale(0, 30, n);
    check(n == 0, "R11 suppressed again", n, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        check(1'b0, "watchdog timeout", 0, 1);
      end
    join_any
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule